// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

The controller collects interrupt requests from two kinds of origin and presents at most one of them to a processor core. Sub-sources are latched in a sub-pending register. Each sub-source is filtered by its own sub-mask bit. Consecutive sub-sources form groups, and each group is OR-merged into one parent main source. Main sources are latched in a source-pending register, either directly from their input line or from their merged group, and are then filtered by a main mask.

Each unmasked pending source goes one of two ways, chosen by its mode bit. A fast-mode source drives the fast-interrupt line directly. A normal-mode source enters a fixed-priority arbiter, in which the lowest source number wins. The winner is captured in a one-hot in-service register, and its number is stored in the vector register. Losing sources stay pending and take part in arbitration again once software has cleared the in-service bit.

Software reaches the block through a single-cycle register port. Writes take effect at the next clock edge. Reads are combinational.

Top module: `irq_ctrl2`

## Requirements
- R1: Reset state. All main-mask and sub-mask bits are 1. The source-pending, sub-pending, mode, in-service and vector registers are 0, and `fiq_o` and `irq_o` are low.
- R2: A high `sub_i` bit sets the matching sub-pending bit at the next edge. The bit then stays set until a 1 is written to it at address 5. Address 5 clears on write-1 and reads back the sub-pending bits.
- R3: A sub-pending bit whose sub-mask bit is 1 never sets its parent source-pending bit. The sub-mask is read/write at address 6.
- R4: Sub-source `s` belongs to group `s / SUB_GRP`. Group `g` is merged into main source `PARENT_BASE + g`. With the defaults, sub-sources 0..2 feed source 28 and sub-sources 9..11 feed source 31. An unmasked pending sub-source sets its parent source-pending bit one edge after its own sub-pending bit is set.
- R5: A high `src_i` bit sets the matching source-pending bit at the next edge. The bit stays set until a 1 is written to it at address 0. Address 0 clears on write-1 and reads back the source-pending bits.
- R6: A source whose main-mask bit is 1 drives neither output. The main mask is read/write at address 2.
- R7: An unmasked pending source whose mode bit is 1 raises `fiq_o` combinationally and never enters the in-service register. The mode register is read/write at address 1.
- R8: Among the unmasked pending normal-mode sources, the lowest-numbered one wins when the in-service register is 0. The in-service register then holds only its bit, and address 4 reads back its number. `irq_o` is high while the in-service register is nonzero.
- R9: While the in-service register is nonzero, it and the vector do not change, except by a write-1-to-clear at address 3. Sources that lost keep their pending bits and are arbitrated one edge after the in-service register becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Direct main-source request lines |
| sub_i | input | SUB_GRP*NGRP | Sub-source request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data for `addr`, zero-extended |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The bench builds the block with its defaults: 32 main sources, and four groups of three sub-sources feeding parents 28 to 31. With these values a single vector table can exercise the priority extremes (source 0 against source 31) as well as masking at both ends of the word. Every sub-source group lands on a parent at the top of the range, so the bench can observe sub-source merging next to direct requests on other bits.

// File: rtl/irq_ctrl2.sv
module irq_ctrl2 #(
  parameter int NSRC        = 32,
  parameter int SUB_GRP     = 3,
  parameter int NGRP        = 4,
  parameter int PARENT_BASE = 28,
  localparam int IDW  = $clog2(NSRC),
  localparam int NSUB = SUB_GRP * NGRP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSUB-1:0] sub_i,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            fiq_o,
  output logic            irq_o
);
  localparam logic [2:0] A_PEND = 3'd0, A_MODE = 3'd1, A_MASK = 3'd2, A_SVC = 3'd3,
                         A_VEC = 3'd4, A_SPEND = 3'd5, A_SMASK = 3'd6;

  logic [NSRC-1:0] src_pend, src_mask, mode_sel, in_svc, merged, live, norm_req, win_hot;
  logic [NSUB-1:0] sub_pend, sub_mask, sub_live;
  logic [IDW-1:0]  vec_num, win_idx;

  wire wr_pend  = wr_en && addr == A_PEND;
  wire wr_svc   = wr_en && addr == A_SVC;
  wire wr_spend = wr_en && addr == A_SPEND;

  assign sub_live = sub_pend & ~sub_mask;
  assign live     = src_pend & ~src_mask;
  assign norm_req = live & ~mode_sel;
  assign fiq_o    = |(live & mode_sel);
  assign irq_o    = |in_svc;

  always_comb begin
    merged = '0;
    for (int g = 0; g < NGRP; g++)
      merged[PARENT_BASE + g] = |sub_live[g*SUB_GRP +: SUB_GRP];
  end

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (norm_req[i]) win_idx = i[IDW-1:0];
    win_hot = NSRC'(1) << win_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_pend <= '0;
      sub_pend <= '0;
      src_mask <= '1;
      sub_mask <= '1;
      mode_sel <= '0;
      in_svc   <= '0;
      vec_num  <= '0;
    end else begin
      sub_pend <= (sub_pend & ~(wr_spend ? wdata[NSUB-1:0] : '0)) | sub_i;
      src_pend <= (src_pend & ~(wr_pend ? wdata : '0)) | src_i | merged;
      if (wr_en && addr == A_MASK)  src_mask <= wdata;
      if (wr_en && addr == A_SMASK) sub_mask <= wdata[NSUB-1:0];
      if (wr_en && addr == A_MODE)  mode_sel <= wdata;
      if (in_svc != '0) begin
        if (wr_svc) in_svc <= in_svc & ~wdata;
      end else if (norm_req != '0) begin
        in_svc  <= win_hot;
        vec_num <= win_idx;
      end
    end
  end

  always_comb begin
    case (addr)
      A_PEND:  rdata = src_pend;
      A_MODE:  rdata = mode_sel;
      A_MASK:  rdata = src_mask;
      A_SVC:   rdata = in_svc;
      A_VEC:   rdata = NSRC'(vec_num);
      A_SPEND: rdata = NSRC'(sub_pend);
      A_SMASK: rdata = NSRC'(sub_mask);
      default: rdata = '0;
    endcase
  end
endmodule

module irq_ctrl2_chk #(
  parameter int NSRC = 32,
  parameter int NSUB = 12,
  parameter int IDW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [NSRC-1:0] in_svc,
  input logic [NSRC-1:0] mode_sel,
  input logic [NSRC-1:0] src_mask,
  input logic [NSUB-1:0] sub_pend,
  input logic [IDW-1:0]  vec_num,
  input logic            fiq_o
);
  assert_svc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_svc));
  assert_vec_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc != '0) |-> in_svc[vec_num]);
  assert_svc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc != '0 && !(wr_en && addr == 3'd3)) |=> ($stable(in_svc) && $stable(vec_num)));
  assert_fast_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc != '0 && $past(in_svc) == '0) |-> (($past(mode_sel) & in_svc) == '0));
  assert_sub_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd5) |=> ((sub_pend & $past(sub_pend)) == $past(sub_pend)));
  assert_mask_fiq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mask == '1) |-> !fiq_o);
endmodule

bind irq_ctrl2 irq_ctrl2_chk #(.NSRC(NSRC), .NSUB(NSUB), .IDW(IDW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .in_svc(in_svc),
  .mode_sel(mode_sel), .src_mask(src_mask), .sub_pend(sub_pend),
  .vec_num(vec_num), .fiq_o(fiq_o));

// File: tb/irq_ctrl2_tb_top.sv
module irq_ctrl2_tb_top;
  logic        clk = 0, rst_n = 0, wr_en = 0, fiq_o, irq_o, done = 0;
  logic [31:0] src_i = '0, wdata = '0, rdata;
  logic [11:0] sub_i = '0;
  logic [2:0]  addr = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_ctrl2 dut_i (.clk(clk), .rst_n(rst_n), .src_i(src_i), .sub_i(sub_i), .wr_en(wr_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .fiq_o(fiq_o), .irq_o(irq_o));

  // {pattern, mask, expected vector, expected irq}
  localparam logic [69:0] VECS [6] = '{
    {32'h0000_0020, 32'h0000_0000, 5'd5,  1'b1},
    {32'h8000_0101, 32'h0000_0000, 5'd0,  1'b1},
    {32'h8000_0101, 32'h0000_0001, 5'd8,  1'b1},
    {32'hF000_0000, 32'h0000_0000, 5'd28, 1'b1},
    {32'h0000_0300, 32'h0000_0300, 5'd0,  1'b0},
    {32'hFFFF_FFFF, 32'h7FFF_FFFF, 5'd31, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_src(input logic [31:0] p);
    src_i = p; @(negedge clk); src_i = '0;
  endtask

  task automatic pulse_sub(input logic [11:0] p);
    sub_i = p; @(negedge clk); sub_i = '0;
  endtask

  task automatic flush();
    wr(3'd5, '1); wr(3'd0, '1); wr(3'd3, '1); @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 fiq", {31'd0, fiq_o}, 0);
    check("R1 irq", {31'd0, irq_o}, 0);
    rd(3'd0, v); check("R1 pend", v, 0);
    rd(3'd1, v); check("R1 mode", v, 0);
    rd(3'd2, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R1 svc", v, 0);
    rd(3'd4, v); check("R1 vec", v, 0);
    rd(3'd5, v); check("R1 spend", v, 0);
    rd(3'd6, v); check("R1 smask", v, 32'h0000_0FFF);

    // R8 R6 table of arbitration cases
    for (int k = 0; k < 6; k++) begin
      flush();
      wr(3'd2, VECS[k][37:6]);
      pulse_src(VECS[k][69:38]);
      rd(3'd0, v); check("R5 pend", v, VECS[k][69:38]);
      @(negedge clk);
      check("R8 R6 irq", {31'd0, irq_o}, {31'd0, VECS[k][0]});
      if (VECS[k][0]) begin
        rd(3'd4, v); check("R8 vec", v, {27'd0, VECS[k][5:1]});
        rd(3'd3, v); check("R8 svc", v, 32'd1 << VECS[k][5:1]);
      end
    end

    // R7 fast path, R6 masking of fast path
    flush();
    wr(3'd1, 32'h8); wr(3'd2, 32'h0);
    pulse_src(32'h8);
    check("R7 fiq", {31'd0, fiq_o}, 1);
    @(negedge clk);
    check("R7 no irq", {31'd0, irq_o}, 0);
    rd(3'd3, v); check("R7 svc", v, 0);
    wr(3'd2, 32'h8);
    check("R6 fiq masked", {31'd0, fiq_o}, 0);
    wr(3'd1, 32'h0);

    // R9 hold and re-arbitration
    flush();
    wr(3'd2, 32'h0);
    pulse_src(32'h84);
    @(negedge clk);
    rd(3'd4, v); check("R9 first", v, 2);
    wr(3'd0, 32'h4);
    pulse_src(32'h2);
    @(negedge clk);
    rd(3'd3, v); check("R9 held", v, 32'h4);
    rd(3'd0, v); check("R9 losers", v, 32'h82);
    wr(3'd3, 32'h4);
    check("R9 drop", {31'd0, irq_o}, 0);
    @(negedge clk);
    check("R9 irq again", {31'd0, irq_o}, 1);
    rd(3'd4, v); check("R9 next", v, 1);
    wr(3'd0, 32'h2); wr(3'd3, 32'h2); @(negedge clk);
    rd(3'd4, v); check("R9 last", v, 7);

    // R2 R3 R4 sub-sources
    wr(3'd2, '1);
    flush();
    wr(3'd6, 32'h10);
    pulse_sub(12'h010);
    rd(3'd5, v); check("R2 spend", v, 32'h10);
    @(negedge clk); @(negedge clk);
    rd(3'd0, v); check("R3 blocked", v, 0);
    pulse_sub(12'h001);
    rd(3'd0, v); check("R4 not yet", v, 0);
    @(negedge clk);
    rd(3'd0, v); check("R4 parent 28", v, 32'h1000_0000);
    wr(3'd5, 32'h1);
    rd(3'd5, v); check("R2 w1c", v, 32'h10);
    wr(3'd6, 32'h0);
    @(negedge clk);
    rd(3'd0, v); check("R4 parent 29", v, 32'h3000_0000);
    pulse_sub(12'h800);
    @(negedge clk);
    rd(3'd0, v); check("R4 parent 31", v, 32'hB000_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule